// File: doc/BRIEF.md
# Segment Translation Unit

This block turns a logical address into a linear address for a processor running with segmentation on. A logical address is a 16-bit selector plus a 32-bit offset. Six segment registers each keep a cached copy of a descriptor. Software loads a register by presenting a selector. The unit then reads the 8-byte descriptor from the global descriptor table through a 32-bit read port and stores the decoded fields in that register's cache entry.

A translate request names a segment register and an offset. One cycle later the unit returns either the linear address or a fault code. Translation uses only the cached entry. A descriptor changed in memory has no effect until its register is loaded again.

Loads that cannot succeed fault at once, without touching memory. These are a bad register number, the local-table bit, a null selector aimed at the code or stack register, and an index past the table limit.

Top module: `seg_xlate_unit`

## Requirements
- R1: A selector is read as index = bits 15:3, table-indicator = bit 2, requested privilege = bits 1:0. Loading a selector with bit 2 set completes with fault code 2 and issues no memory read.
- R2: A descriptor load issues exactly two reads. The first read is at tbl_base + index*8 and returns the low word. The second read is at that address + 4 and returns the high word.
- R3: If index*8 + 7 exceeds tbl_limit, the load completes with fault code 4, issues no read and leaves the register unchanged.
- R4: The low word holds limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. The high word holds the following fields:
  - base[23:16] in bits 7:0
  - the access byte in bits 15:8, with type in 11:8, S in 12, DPL in 14:13 and present in 15
  - limit[19:16] in bits 19:16
  - flags in bits 23:20, with D/B in 22 and granularity in 23
  - base[31:24] in bits 31:24
- R5: With granularity clear, the effective limit is the 20-bit limit counted in bytes. With granularity set, it is {limit, 12'hFFF}.
- R6: A translate whose offset is above the effective limit returns fault code 7. An offset equal to the limit is accepted. Every faulting translate returns linear address 0.
- R7: Loading a descriptor whose present bit is clear completes with fault code 5 and leaves the register's previous cache entry in use.
- R8: Loading a null selector (index 0, bit 2 clear, any RPL) into ES, DS, FS or GS does not fault and issues no read. A later translate through that register returns fault code 6. After reset every register is in this unusable state.
- R9: Loading a null selector into CS (register 1) or SS (register 2) faults with code 3.
- R10: xl_valid is high exactly in the cycle after xl_req. A successful translate returns lin_addr = base + offset modulo 2^32. The translate also reports the cached DPL and the selector's RPL.
- R11: A translate uses the cached entry. Rewriting the descriptor in memory changes the result only after the register is reloaded.
- R12: Register numbers are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. A register number of 6 or 7 gives fault code 1, for both load and translate.
- R13: busy is high from the cycle after a fetching load is accepted until the load completes. mem_req is high only while busy. ld_done is a one-cycle pulse. ld_req is accepted only while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_base | input | 32 | Linear base address of the descriptor table |
| tbl_limit | input | 16 | Byte limit of the descriptor table |
| ld_req | input | 1 | Selector load request |
| ld_sreg | input | 3 | Segment register number for the load |
| ld_sel | input | 16 | Selector to load |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read data valid for the current request |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | Load complete pulse |
| ld_fault | output | 3 | Load fault code, valid with ld_done |
| xl_req | input | 1 | Translate request |
| xl_sreg | input | 3 | Segment register number for the translate |
| xl_offset | input | 32 | Offset to translate |
| xl_valid | output | 1 | Translate result valid |
| xl_fault | output | 3 | Translate fault code |
| lin_addr | output | 32 | Linear address, 0 on fault |
| xl_dpl | output | 2 | Cached descriptor privilege level |
| xl_rpl | output | 2 | Requested privilege level of the cached selector |

## Verification
The assertions check on every cycle the properties that depend only on the request pins and a fixed delay:
- the one-cycle translate latency and its idle counterpart;
- the zero address on every faulting translate;
- the handling of a bad register number;
- the immediate local-table and null-code faults;
- mem_req being confined to busy.

Other behaviours depend on memory contents and on history, so only the bench scenarios can show them:
- the two-read fetch and its addresses;
- the field decode and the granularity scaling;
- the present check, and a failed load leaving the old entry in place;
- a stale cache entry surviving a change to the table.

// File: rtl/seg_xlate_pkg.sv
// Shared types for the segment translation unit: fault codes, register
// numbering and the cached descriptor record with its decode function.
// Assumes the descriptor layout given in the brief (R4).
package seg_xlate_pkg;

    localparam int SREG_COUNT = 6;
    localparam int SREG_IDX_W = 3;
    localparam int SEL_W      = 16;
    localparam int LIN_W      = 32;
    localparam int TLIM_W     = 16;

    localparam logic [SREG_IDX_W-1:0] SREG_CS = 3'd1;
    localparam logic [SREG_IDX_W-1:0] SREG_SS = 3'd2;

    typedef enum logic [2:0] {
        FLT_NONE        = 3'd0,
        FLT_BAD_REG     = 3'd1,
        FLT_LOCAL       = 3'd2,
        FLT_NULL_LOAD   = 3'd3,
        FLT_TBL_LIMIT   = 3'd4,
        FLT_NOT_PRESENT = 3'd5,
        FLT_UNUSABLE    = 3'd6,
        FLT_SEG_LIMIT   = 3'd7
    } seg_fault_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [LIN_W-1:0] base;
        logic [19:0]      limit;
        logic             gran;
        logic             present;
        logic [1:0]       dpl;
        logic             sys_n;
        logic [3:0]       kind;
        logic             def_big;
        logic             usable;
    } seg_cache_t;

    // Assemble a cache record from the selector and the two descriptor words.
    function automatic seg_cache_t unpack_desc(input logic [SEL_W-1:0] sel,
                                               input logic [31:0] lo,
                                               input logic [31:0] hi);
        seg_cache_t e;
        e.sel     = sel;
        e.base    = {hi[31:24], hi[7:0], lo[31:16]};
        e.limit   = {hi[19:16], lo[15:0]};
        e.gran    = hi[23];
        e.def_big = hi[22];
        e.present = hi[15];
        e.dpl     = hi[14:13];
        e.sys_n   = hi[12];
        e.kind    = hi[11:8];
        e.usable  = hi[15];
        return e;
    endfunction

endpackage

// File: rtl/seg_sel_check.sv
// Combinational selector screening for a load request. Classifies the
// selector as null and returns the fault that ends the load without a
// memory read. Assumes a 16-bit table limit (byte granular).
module seg_sel_check
    import seg_xlate_pkg::*;
(
    input  logic [SREG_IDX_W-1:0] sreg,
    input  logic [SEL_W-1:0]      sel,
    input  logic [TLIM_W-1:0]     tbl_limit,
    output logic                  is_null,
    output seg_fault_e            fault
);

    logic [TLIM_W-1:0] last_byte;

    assign last_byte = {sel[15:3], 3'b111};

    // Prioritised early-fault decision for the requested load.
    always_comb begin
        is_null = (sel[15:3] == 13'd0) && !sel[2];
        if (int'(sreg) >= SREG_COUNT)
            fault = FLT_BAD_REG;
        else if (sel[2])
            fault = FLT_LOCAL;
        else if (is_null && (sreg == SREG_CS || sreg == SREG_SS))
            fault = FLT_NULL_LOAD;
        else if (!is_null && (last_byte > tbl_limit))
            fault = FLT_TBL_LIMIT;
        else
            fault = FLT_NONE;
    end

endmodule

// File: rtl/seg_desc_fetch.sv
// Load sequencer. Accepts a selector load, finishes early-fault and null
// loads at once, otherwise reads the descriptor as two 32-bit words and
// writes the cache on the cycle the high word arrives. Assumes mem_rdata
// is valid in any cycle mem_ack is high while mem_req is high.
module seg_desc_fetch
    import seg_xlate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_req,
    input  logic [SREG_IDX_W-1:0] ld_sreg,
    input  logic [SEL_W-1:0]      ld_sel,
    input  logic [LIN_W-1:0]      tbl_base,
    input  seg_fault_e            chk_fault,
    input  logic                  chk_null,
    output logic                  mem_req,
    output logic [LIN_W-1:0]      mem_addr,
    input  logic                  mem_ack,
    input  logic [31:0]           mem_rdata,
    output logic                  busy,
    output logic                  ld_done,
    output logic [2:0]            ld_fault,
    output logic                  wr_en,
    output logic [SREG_IDX_W-1:0] wr_idx,
    output seg_cache_t            wr_entry
);

    typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} fetch_st_e;

    fetch_st_e             st_q;
    logic [SREG_IDX_W-1:0] sreg_q;
    logic [SEL_W-1:0]      sel_q;
    logic [LIN_W-1:0]      addr_q;
    logic [31:0]           lo_q;
    seg_cache_t            fetched;
    seg_cache_t            null_ent;
    logic                  accept;

    assign accept   = (st_q == ST_IDLE) && ld_req;
    assign busy     = (st_q != ST_IDLE);
    assign mem_req  = busy;
    assign mem_addr = (st_q == ST_HI) ? addr_q + 32'd4 : addr_q;
    assign fetched  = unpack_desc(sel_q, lo_q, mem_rdata);

    // Null record: selector kept for its RPL, everything else cleared.
    always_comb begin
        null_ent     = '0;
        null_ent.sel = ld_sel;
    end

    // Cache write port: null data loads on accept, fetched present entries on the high word.
    always_comb begin
        wr_en    = 1'b0;
        wr_idx   = sreg_q;
        wr_entry = fetched;
        if (accept && chk_fault == FLT_NONE && chk_null) begin
            wr_en    = 1'b1;
            wr_idx   = ld_sreg;
            wr_entry = null_ent;
        end else if (st_q == ST_HI && mem_ack && fetched.present) begin
            wr_en = 1'b1;
        end
    end

    // Sequencer state, captured request and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            sreg_q   <= '0;
            sel_q    <= '0;
            addr_q   <= '0;
            lo_q     <= '0;
            ld_done  <= 1'b0;
            ld_fault <= FLT_NONE;
        end else begin
            ld_done <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (ld_req) begin
                        sreg_q <= ld_sreg;
                        sel_q  <= ld_sel;
                        addr_q <= tbl_base + {16'd0, ld_sel[15:3], 3'b000};
                        if (chk_fault != FLT_NONE || chk_null) begin
                            ld_done  <= 1'b1;
                            ld_fault <= chk_fault;
                        end else begin
                            st_q <= ST_LO;
                        end
                    end
                end
                ST_LO: begin
                    if (mem_ack) begin
                        lo_q <= mem_rdata;
                        st_q <= ST_HI;
                    end
                end
                ST_HI: begin
                    if (mem_ack) begin
                        st_q     <= ST_IDLE;
                        ld_done  <= 1'b1;
                        ld_fault <= fetched.present ? FLT_NONE : FLT_NOT_PRESENT;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/seg_cache.sv
// Per-register descriptor cache: one record per segment register, one
// write port and one combinational read port. Reset leaves every entry
// unusable with a zero selector.
module seg_cache
    import seg_xlate_pkg::*;
#(
    parameter int NUM = SREG_COUNT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SREG_IDX_W-1:0] wr_idx,
    input  seg_cache_t            wr_entry,
    input  logic [SREG_IDX_W-1:0] rd_idx,
    output seg_cache_t            rd_entry
);

    seg_cache_t ent_q [NUM];

    for (genvar i = 0; i < NUM; i++) begin : g_ent
        // Hold one register's cached descriptor until it is rewritten.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[i] <= '0;
            else if (wr_en && int'(wr_idx) == i)
                ent_q[i] <= wr_entry;
        end
    end

    // Select the entry named by the read index, zero when out of range.
    always_comb begin
        rd_entry = '0;
        for (int i = 0; i < NUM; i++)
            if (int'(rd_idx) == i)
                rd_entry = ent_q[i];
    end

endmodule

// File: rtl/seg_xlate_path.sv
// Translate datapath: limit scaling, limit compare and base add in
// parallel, registered once. Assumes expand-up segments only.
module seg_xlate_path
    import seg_xlate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xl_req,
    input  logic [SREG_IDX_W-1:0] xl_sreg,
    input  logic [LIN_W-1:0]      xl_offset,
    input  seg_cache_t            ent,
    output logic                  xl_valid,
    output logic [2:0]            xl_fault,
    output logic [LIN_W-1:0]      lin_addr,
    output logic [1:0]            xl_dpl,
    output logic [1:0]            xl_rpl
);

    logic [LIN_W-1:0] eff_limit;
    logic [LIN_W-1:0] sum;
    seg_fault_e       flt;

    assign eff_limit = ent.gran ? {ent.limit, 12'hFFF} : {12'h000, ent.limit};
    assign sum       = ent.base + xl_offset;

    // Prioritised translate fault decision.
    always_comb begin
        if (int'(xl_sreg) >= SREG_COUNT)
            flt = FLT_BAD_REG;
        else if (!ent.usable)
            flt = FLT_UNUSABLE;
        else if (xl_offset > eff_limit)
            flt = FLT_SEG_LIMIT;
        else
            flt = FLT_NONE;
    end

    // Register the translate result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_valid <= 1'b0;
            xl_fault <= FLT_NONE;
            lin_addr <= '0;
            xl_dpl   <= '0;
            xl_rpl   <= '0;
        end else begin
            xl_valid <= xl_req;
            if (xl_req) begin
                xl_fault <= flt;
                lin_addr <= (flt == FLT_NONE) ? sum : '0;
                xl_dpl   <= ent.dpl;
                xl_rpl   <= ent.sel[1:0];
            end
        end
    end

endmodule

// File: rtl/seg_xlate_unit.sv
// Segment translation unit top: selector screening, descriptor fetch,
// per-register cache and translate path. Loads and translates may
// overlap; a translate sees the cache as it stood before the edge.
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SREG = SREG_COUNT
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] tbl_base,
    input  logic [15:0] tbl_limit,
    input  logic        ld_req,
    input  logic [2:0]  ld_sreg,
    input  logic [15:0] ld_sel,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        busy,
    output logic        ld_done,
    output logic [2:0]  ld_fault,
    input  logic        xl_req,
    input  logic [2:0]  xl_sreg,
    input  logic [31:0] xl_offset,
    output logic        xl_valid,
    output logic [2:0]  xl_fault,
    output logic [31:0] lin_addr,
    output logic [1:0]  xl_dpl,
    output logic [1:0]  xl_rpl
);

    seg_fault_e            chk_fault;
    logic                  chk_null;
    logic                  wr_en;
    logic [SREG_IDX_W-1:0] wr_idx;
    seg_cache_t            wr_entry;
    seg_cache_t            rd_entry;

    seg_sel_check u_sel_check (
        .sreg      (ld_sreg),
        .sel       (ld_sel),
        .tbl_limit (tbl_limit),
        .is_null   (chk_null),
        .fault     (chk_fault)
    );

    seg_desc_fetch u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_req    (ld_req),
        .ld_sreg   (ld_sreg),
        .ld_sel    (ld_sel),
        .tbl_base  (tbl_base),
        .chk_fault (chk_fault),
        .chk_null  (chk_null),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .ld_done   (ld_done),
        .ld_fault  (ld_fault),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_entry  (wr_entry)
    );

    seg_cache #(.NUM(NUM_SREG)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .rd_idx   (xl_sreg),
        .rd_entry (rd_entry)
    );

    seg_xlate_path u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .xl_req    (xl_req),
        .xl_sreg   (xl_sreg),
        .xl_offset (xl_offset),
        .ent       (rd_entry),
        .xl_valid  (xl_valid),
        .xl_fault  (xl_fault),
        .lin_addr  (lin_addr),
        .xl_dpl    (xl_dpl),
        .xl_rpl    (xl_rpl)
    );

endmodule

// File: rtl/seg_xlate_unit_chk.sv
// Protocol and timing checks on the segment translation unit's ports,
// bound into every instance of the top module.
module seg_xlate_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ld_req,
    input logic [2:0]  ld_sreg,
    input logic [15:0] ld_sel,
    input logic        mem_req,
    input logic        busy,
    input logic        ld_done,
    input logic [2:0]  ld_fault,
    input logic        xl_req,
    input logic [2:0]  xl_sreg,
    input logic        xl_valid,
    input logic [2:0]  xl_fault,
    input logic [31:0] lin_addr
);

    p_mem_in_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_xl_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> xl_valid);

    p_xl_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_req |=> !xl_valid);

    p_fault_zero_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && xl_fault != 3'd0) |-> (lin_addr == 32'd0));

    p_bad_reg_xl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && xl_sreg > 3'd5) |=> (xl_fault == 3'd1));

    p_local_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !busy && ld_sel[2] && ld_sreg <= 3'd5) |=> (ld_done && ld_fault == 3'd2));

    p_null_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !busy && (ld_sreg == 3'd1 || ld_sreg == 3'd2) && ld_sel[15:2] == 14'd0)
        |=> (ld_done && ld_fault == 3'd3));

endmodule

bind seg_xlate_unit seg_xlate_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_req   (ld_req),
    .ld_sreg  (ld_sreg),
    .ld_sel   (ld_sel),
    .mem_req  (mem_req),
    .busy     (busy),
    .ld_done  (ld_done),
    .ld_fault (ld_fault),
    .xl_req   (xl_req),
    .xl_sreg  (xl_sreg),
    .xl_valid (xl_valid),
    .xl_fault (xl_fault),
    .lin_addr (lin_addr)
);

// File: tb/seg_xlate_unit_tb.sv
// Self-checking bench: descriptor table in a small memory model with a
// same-cycle acknowledge, a table of translate vectors, then directed cases.
module seg_xlate_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TB_BASE = 32'h1000_0000;
    localparam int NVEC = 11;
    // {sreg[3], offset[32], expected fault[3], expected linear[32]}
    localparam logic [69:0] VEC [NVEC] = '{
        {3'd1, 32'h0010_0000, 3'd0, 32'h0010_0000},
        {3'd1, 32'hFFFF_FFFF, 3'd0, 32'hFFFF_FFFF},
        {3'd3, 32'h0000_0FFF, 3'd0, 32'h1234_6677},
        {3'd3, 32'h0000_1000, 3'd7, 32'h0000_0000},
        {3'd3, 32'h0000_0000, 3'd0, 32'h1234_5678},
        {3'd0, 32'h0000_1FFF, 3'd0, 32'h0000_0FFF},
        {3'd0, 32'h0000_2000, 3'd7, 32'h0000_0000},
        {3'd4, 32'h0000_0000, 3'd6, 32'h0000_0000},
        {3'd5, 32'h0000_0004, 3'd6, 32'h0000_0000},
        {3'd6, 32'h0000_0000, 3'd1, 32'h0000_0000},
        {3'd2, 32'h0000_0100, 3'd0, 32'h0000_0100}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] tbl_base;
    logic [15:0] tbl_limit;
    logic        ld_req;
    logic [2:0]  ld_sreg;
    logic [15:0] ld_sel;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        busy;
    logic        ld_done;
    logic [2:0]  ld_fault;
    logic        xl_req;
    logic [2:0]  xl_sreg;
    logic [31:0] xl_offset;
    logic        xl_valid;
    logic [2:0]  xl_fault;
    logic [31:0] lin_addr;
    logic [1:0]  xl_dpl;
    logic [1:0]  xl_rpl;

    logic [31:0] mem [0:31];
    int          rd_total = 0;
    logic [31:0] rd_prev = '0;
    logic [31:0] rd_last = '0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[6:2]];

    seg_xlate_unit u_dut (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
        .ld_req(ld_req), .ld_sreg(ld_sreg), .ld_sel(ld_sel),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .ld_done(ld_done), .ld_fault(ld_fault),
        .xl_req(xl_req), .xl_sreg(xl_sreg), .xl_offset(xl_offset),
        .xl_valid(xl_valid), .xl_fault(xl_fault), .lin_addr(lin_addr),
        .xl_dpl(xl_dpl), .xl_rpl(xl_rpl)
    );

    // Record every read cycle and the last two addresses.
    always @(negedge clk) begin
        if (mem_req) begin
            rd_total <= rd_total + 1;
            rd_prev  <= rd_last;
            rd_last  <= mem_addr;
        end
    end

    function automatic logic [31:0] mk_lo(input logic [31:0] b, input logic [19:0] l);
        return {b[15:0], l[15:0]};
    endfunction

    function automatic logic [31:0] mk_hi(input logic [31:0] b, input logic [19:0] l,
                                          input logic [7:0] acc, input logic [3:0] flg);
        return {b[31:24], flg, l[19:16], acc, b[23:16]};
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_load(input logic [2:0] r, input logic [15:0] s,
                           output logic [2:0] f, output int nrd);
        int c0;
        @(negedge clk);
        ld_req = 1'b1; ld_sreg = r; ld_sel = s;
        c0 = rd_total;
        @(negedge clk);
        ld_req = 1'b0;
        for (int k = 0; k < 20 && !ld_done; k++) @(negedge clk);
        f   = ld_done ? ld_fault : 3'bxxx;
        nrd = rd_total - c0;
    endtask

    task automatic do_xl(input logic [2:0] r, input logic [31:0] off);
        @(negedge clk);
        xl_req = 1'b1; xl_sreg = r; xl_offset = off;
        @(negedge clk);
        xl_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [2:0] f;
        int         nrd;
        for (int i = 0; i < 32; i++) mem[i] = '0;
        mem[2]  = mk_lo(32'h0, 20'hFFFFF);        mem[3]  = mk_hi(32'h0, 20'hFFFFF, 8'h9A, 4'hC);
        mem[4]  = mk_lo(32'h0, 20'hFFFFF);        mem[5]  = mk_hi(32'h0, 20'hFFFFF, 8'h92, 4'hC);
        mem[6]  = mk_lo(32'h12345678, 20'h00FFF); mem[7]  = mk_hi(32'h12345678, 20'h00FFF, 8'hF2, 4'h4);
        mem[8]  = mk_lo(32'h0, 20'hFFFFF);        mem[9]  = mk_hi(32'h0, 20'hFFFFF, 8'h12, 4'hC);
        mem[10] = mk_lo(32'hFFFFF000, 20'h00001); mem[11] = mk_hi(32'hFFFFF000, 20'h00001, 8'h92, 4'h8);
        tbl_base = TB_BASE; tbl_limit = 16'h003F;
        ld_req = 0; ld_sreg = 0; ld_sel = 0; xl_req = 0; xl_sreg = 0; xl_offset = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R13 reset busy", {31'd0, busy}, 32'd0);
        chk("R13 reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("R10 reset xl_valid", {31'd0, xl_valid}, 32'd0);
        rst_n = 1'b1;

        // R8: registers are unusable after reset
        do_xl(3'd3, 32'd0);
        chk("R8 reset-state translate fault", {29'd0, xl_fault}, 32'd6);

        // Setup loads for the vector table
        do_load(3'd1, 16'h0008, f, nrd); chk("R4 load CS", {29'd0, f}, 32'd0);
        do_load(3'd2, 16'h0010, f, nrd); chk("R4 load SS", {29'd0, f}, 32'd0);
        do_load(3'd3, 16'h001B, f, nrd); chk("R4 load DS", {29'd0, f}, 32'd0);
        do_load(3'd0, 16'h0028, f, nrd); chk("R4 load ES", {29'd0, f}, 32'd0);
        do_load(3'd4, 16'h0000, f, nrd); chk("R8 null FS fault", {29'd0, f}, 32'd0);
        chk("R8 null FS reads", nrd, 32'd0);
        do_load(3'd5, 16'h0003, f, nrd); chk("R8 null GS fault", {29'd0, f}, 32'd0);

        // Vector table: R5 scaling, R6 limit, R8 null use, R10 sum and wrap, R12 bad register
        for (int i = 0; i < NVEC; i++) begin
            do_xl(VEC[i][69:67], VEC[i][66:35]);
            chk($sformatf("R10 vector %0d valid", i), {31'd0, xl_valid}, 32'd1);
            chk($sformatf("R6 vector %0d fault", i), {29'd0, xl_fault}, {29'd0, VEC[i][34:32]});
            chk($sformatf("R10 vector %0d linear", i), lin_addr, VEC[i][31:0]);
        end

        // R4 decode and R10 privilege report
        do_xl(3'd3, 32'd0);
        chk("R4 decoded base", lin_addr, 32'h12345678);
        chk("R10 dpl", {30'd0, xl_dpl}, 32'd3);
        chk("R10 rpl", {30'd0, xl_rpl}, 32'd3);
        // R5 granularity boundary
        do_xl(3'd0, 32'h0000_1FFF);
        chk("R5 scaled limit edge", {29'd0, xl_fault}, 32'd0);

        // R7 non-present load leaves old entry
        do_load(3'd3, 16'h0020, f, nrd);
        chk("R7 not present fault", {29'd0, f}, 32'd5);
        chk("R7 reads", nrd, 32'd2);
        do_xl(3'd3, 32'd0);
        chk("R7 old entry kept", lin_addr, 32'h12345678);

        // R3 table limit
        do_load(3'd3, 16'h0040, f, nrd);
        chk("R3 table limit fault", {29'd0, f}, 32'd4);
        chk("R3 no reads", nrd, 32'd0);
        do_xl(3'd3, 32'd0);
        chk("R3 entry kept", lin_addr, 32'h12345678);

        // R1 local table bit
        do_load(3'd3, 16'h000C, f, nrd);
        chk("R1 local fault", {29'd0, f}, 32'd2);
        chk("R1 no reads", nrd, 32'd0);

        // R9 null into CS and SS
        do_load(3'd1, 16'h0000, f, nrd);
        chk("R9 null CS", {29'd0, f}, 32'd3);
        do_load(3'd2, 16'h0003, f, nrd);
        chk("R9 null SS", {29'd0, f}, 32'd3);
        do_xl(3'd1, 32'h40);
        chk("R9 CS still usable", lin_addr, 32'h40);

        // R12 bad register on load
        do_load(3'd6, 16'h0010, f, nrd);
        chk("R12 bad register load", {29'd0, f}, 32'd1);

        // R2 read addresses
        do_load(3'd3, 16'h001B, f, nrd);
        chk("R2 read count", nrd, 32'd2);
        chk("R2 first address", rd_prev, TB_BASE + 32'h18);
        chk("R2 second address", rd_last, TB_BASE + 32'h1C);

        // R11 stale cache until reload
        mem[7] = mk_hi(32'h22345678, 20'h00FFF, 8'hF2, 4'h4);
        do_xl(3'd3, 32'd0);
        chk("R11 cached base kept", lin_addr, 32'h12345678);
        do_load(3'd3, 16'h001B, f, nrd);
        do_xl(3'd3, 32'd0);
        chk("R11 reload picks new base", lin_addr, 32'h22345678);

        // R13 busy and done pulse
        @(negedge clk);
        ld_req = 1'b1; ld_sreg = 3'd2; ld_sel = 16'h0010;
        @(negedge clk);
        ld_req = 1'b0;
        chk("R13 busy during fetch", {31'd0, busy}, 32'd1);
        for (int k = 0; k < 20 && !ld_done; k++) @(negedge clk);
        chk("R13 done seen", {31'd0, ld_done}, 32'd1);
        chk("R13 idle at done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R13 done is one pulse", {31'd0, ld_done}, 32'd0);

        finish_run();
    end

endmodule